// File: doc/BRIEF.md
# Greyscale to RGB444 pixel expander

The block takes 32-bit framebuffer words that hold packed greyscale pixels at 1, 2 or 4 bits per pixel and turns each pixel into one 12-bit RGB444 display pixel. Pixels leave a word starting from its least-significant end. Each grey value is bit-inverted first, because a cleared framebuffer bit means white on the display. The inverted value is then replicated until it fills all 12 bits, so the darkest and lightest codes reach full black and full white.

The input is a valid/ready stream of words. The output is a one-cycle `out_valid` strobe carrying `out_pix`. The consumer paces it with tokens: each pulse on `out_take` grants room for exactly one further pixel. A single token is held from reset, so the first pixel needs no grant. At most one token is held at a time. A new word is accepted only after the last pixel of the current word has been emitted. The depth select is sampled when a word is accepted, so a depth change takes effect on the next word boundary.

Top module: `grey_rgb_expander`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Pixels of a word are emitted in order from its least-significant end, each pixel occupying the next `bpp` bits.
- R3: With `depth` = 2'b10 (4 bpp, and 2'b11 is treated the same way), the pixel is the inverted nibble `v`, and `out_pix` = {v, v, v}.
- R4: With `depth` = 2'b01 (2 bpp), the inverted 2-bit value is repeated six times, so the codes 00, 01, 10 and 11 give 12'hFFF, 12'hAAA, 12'h555 and 12'h000.
- R5: With `depth` = 2'b00 (1 bpp), a 0 bit gives 12'hFFF and a 1 bit gives 12'h000.
- R6: A word yields 8, 16 or 32 pixels at 4, 2 or 1 bpp. `in_ready` is 0 from the cycle after a word is accepted until the last pixel of that word is emitted, and it returns to 1 in the same cycle as that pixel's `out_valid`.
- R7: The value of `depth` is taken only when a word is accepted. A change while a word is being emitted does not affect the pixels of that word.
- R8: One pixel is emitted per held token. One token is held from reset. A token pulse while a token is already held is not stored, so two such pulses allow only one pixel.
- R9: While no token is held, `out_valid` stays 0 even when a word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input word is offered |
| in_data | input | 32 | Packed greyscale word |
| in_ready | output | 1 | The block can take a word |
| depth | input | 2 | 00 = 1 bpp, 01 = 2 bpp, 10 and 11 = 4 bpp |
| out_valid | output | 1 | One-cycle strobe: `out_pix` is a new pixel |
| out_pix | output | 12 | RGB444 pixel, red in the top nibble |
| out_take | input | 1 | Consumer token pulse: room for one more pixel |

## Verification
The bench uses the default 32-bit word and 4-bit channel. With these values the 1 bpp case drives the pixel counter through its full range of 32, and the 4 bpp case uses the channel width exactly with no replication. Vectors at every depth cover all four 2-bit codes and both ends of the grey range. Directed cases withhold tokens, send surplus tokens, and change the depth while a word is being emitted.

// File: rtl/grey_rgb_expander.sv
module grey_rgb_expander #(
  parameter int WORD_W = 32,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic [1:0]        depth,
  output logic              out_valid,
  output logic [3*CH_W-1:0] out_pix,
  input  logic              out_take
);
  localparam int CNT_W = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] word_q;
  logic [1:0]        dep_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;
  logic              cred_q;
  logic [3:0]        inv;
  logic [CH_W-1:0]   chan;
  int                bw;

  wire load = in_valid && !busy_q;
  wire emit = busy_q && cred_q;

  assign in_ready = !busy_q;

  function automatic logic [1:0] lg_bpp(input logic [1:0] d);
    case (d)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  always_comb begin
    case (dep_q)
      2'b00:   begin inv = {3'b000, ~word_q[0]};   bw = 1; end
      2'b01:   begin inv = {2'b00, ~word_q[1:0]};  bw = 2; end
      default: begin inv = ~word_q[3:0];           bw = 4; end
    endcase
    for (int j = 0; j < CH_W; j++)
      chan[j] = inv[j % bw];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q    <= '0;
      dep_q     <= 2'b00;
      left_q    <= '0;
      busy_q    <= 1'b0;
      cred_q    <= 1'b1;
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= emit;
      cred_q    <= out_take | (cred_q & ~emit);
      if (emit)
        out_pix <= {3{chan}};
      if (load) begin
        word_q <= in_data;
        dep_q  <= depth;
        left_q <= CNT_W'(WORD_W) >> lg_bpp(depth);
        busy_q <= 1'b1;
      end else if (emit) begin
        word_q <= word_q >> bw;
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1))
          busy_q <= 1'b0;
      end
    end
  end
endmodule

module grey_rgb_expander_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_take
);
  logic m_cred;
  logic take_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_cred <= 1'b1;
      take_q <= 1'b0;
    end else begin
      m_cred <= take_q | (m_cred & ~out_valid);
      take_q <= out_take;
    end
  end

  a_r8_one_per_credit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> m_cred);

  a_r9_valid_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r6_ready_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> out_valid);
endmodule

bind grey_rgb_expander grey_rgb_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_take(out_take)
);

// File: tb/grey_rgb_expander_tb.sv
module grey_rgb_expander_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic [1:0]  depth = 2'b00;
  logic        out_valid;
  logic [11:0] out_pix;
  logic        out_take = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grey_rgb_expander u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .depth(depth), .out_valid(out_valid),
    .out_pix(out_pix), .out_take(out_take)
  );

  typedef struct packed {
    logic [1:0]  d;
    logic [31:0] w;
    logic [11:0] first;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'b10, 32'h7654_3210, 12'hFFF},
    '{2'b01, 32'hE4E4_E4E4, 12'hFFF},
    '{2'b00, 32'h0000_FFFF, 12'h000},
    '{2'b11, 32'hFEDC_BA98, 12'h777},
    '{2'b00, 32'hAAAA_AAAA, 12'hFFF},
    '{2'b01, 32'h1B1B_1B1B, 12'h000}
  };

  function automatic int bits_of(input logic [1:0] d);
    return (d == 2'b00) ? 1 : (d == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [11:0] exp_pix(input logic [1:0] d, input logic [31:0] w, input int i);
    int b;
    logic [3:0] f;
    logic [11:0] r;
    b = bits_of(d);
    f = 4'((w >> (i * b)) & ((1 << b) - 1));
    f = ~f & 4'((1 << b) - 1);
    for (int k = 0; k < 12; k++) r[k] = f[k % b];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_take = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_word(input logic [1:0] d, input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = w;
    depth = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 busy after accept", {31'd0, in_ready}, 32'd0);
  endtask

  task automatic wait_pix(output bit got);
    got = 0;
    for (int t = 0; t < 20 && !got; t++) begin
      if (out_valid) got = 1;
      else @(negedge clk);
    end
  endtask

  task automatic give_token();
    out_take = 1'b1;
    @(negedge clk);
    out_take = 1'b0;
  endtask

  task automatic collect(input logic [1:0] d, input logic [31:0] w, input int from, input string req);
    int n;
    bit got;
    n = 32 / bits_of(d);
    for (int i = from; i < n; i++) begin
      wait_pix(got);
      if (!got) begin
        check({req, " pixel timeout"}, 32'd0, 32'd1);
        return;
      end
      check(req, {20'd0, out_pix}, {20'd0, exp_pix(d, w, i)});
      if (i == n - 1)
        check("R6 ready with last pixel", {31'd0, in_ready}, 32'd1);
      else if (i == 0)
        check("R6 not ready mid-word", {31'd0, in_ready}, 32'd0);
      give_token();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    bit got;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 ready in reset", {31'd0, in_ready}, 32'd1);
    do_reset();
    @(negedge clk);
    check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 ready after reset", {31'd0, in_ready}, 32'd1);

    for (int v = 0; v < 6; v++) begin
      send_word(VECS[v].d, VECS[v].w);
      wait_pix(got);
      check("R2 first pixel from low end", {20'd0, out_pix}, {20'd0, VECS[v].first});
      case (VECS[v].d)
        2'b00:   collect(VECS[v].d, VECS[v].w, 0, "R5 1bpp pixel");
        2'b01:   collect(VECS[v].d, VECS[v].w, 0, "R4 2bpp pixel");
        default: collect(VECS[v].d, VECS[v].w, 0, "R3 4bpp pixel");
      endcase
    end

    // R9: withhold the token after the first pixel
    do_reset();
    send_word(2'b10, 32'h0000_00F0);
    wait_pix(got);
    check("R3 pixel before stall", {20'd0, out_pix}, 12'hFFF);
    @(negedge clk);
    cnt = 0;
    for (int t = 0; t < 12; t++) begin
      if (out_valid) cnt++;
      @(negedge clk);
    end
    check("R9 no output without token", cnt, 0);
    give_token();
    collect(2'b10, 32'h0000_00F0, 1, "R9 resume after token");

    // R8: surplus tokens do not stack
    give_token();
    give_token();
    send_word(2'b00, 32'h5555_5555);
    cnt = 0;
    for (int t = 0; t < 20; t++) begin
      if (out_valid) cnt++;
      if (t < 19) @(negedge clk);
    end
    check("R8 one pixel per held token", cnt, 1);
    give_token();
    collect(2'b00, 32'h5555_5555, 1, "R8 drain after token");

    // R7: depth change mid-word
    do_reset();
    send_word(2'b10, 32'h0123_4567);
    depth = 2'b00;
    collect(2'b10, 32'h0123_4567, 0, "R7 depth held for word");
    send_word(2'b00, 32'h8000_0001);
    collect(2'b00, 32'h8000_0001, 0, "R7 new depth at boundary");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule